// File: doc/BRIEF.md
# Level-Crossing Trigger Detector

This block watches one of several digitized sample streams and emits a one-cycle trigger pulse when the chosen stream meets a programmable level condition. Each stream delivers samples with a per-stream valid strobe. A source-select input chooses the stream that is monitored. That stream may be one of the acquisition channels or a dedicated external trigger input.

The top eight bits of each accepted sample are compared against a low level and a high level. One of five conditions is then applied:

- **Below:** the sample is under the low level.
- **Above:** the sample is over the high level.
- **Inside:** the sample lies within the band between the two levels.
- **High hysteresis:** the detector is armed by a sample under the low level and fires on the next sample over the high level.
- **Low hysteresis:** the detector is armed by a sample over the high level and fires on the next sample under the low level.

Every trigger is an edge event. A new pulse needs the condition to go false first, or the detector to re-arm.

The block sits between the sample sources and the acquisition sequencer, which treats the pulse as its start event. Changing the condition code or the source select discards the history built up under the old setting.

Top module: `trig_level_detector`

## Requirements
- R1: The monitored sample and strobe come from stream `src_sel` (streams are packed in `smp_data` at bits `[i*SAMPLE_W +: SAMPLE_W]`, strobe `smp_valid[i]`). A select value of `NUM_SRC` or more monitors nothing and never triggers. Samples on other streams have no effect.
- R2: The comparison level is bits `[SAMPLE_W-1 -: 8]` of the sample, taken as unsigned. Lower sample bits do not affect the result.
- R3: Only samples whose strobe is high are evaluated. A triggering sample accepted at clock edge k drives `trig_pulse` high for the cycle following edge k.
- R4: Condition code 0 (below) fires on a sample whose level is less than `lvl_lo` when the previous evaluated sample was not below.
- R5: Condition code 1 (above) fires on a sample whose level is greater than `lvl_hi` when the previous evaluated sample was not above.
- R6: Condition code 2 (inside) fires on a sample with `lvl_lo <= level <= lvl_hi` (both bounds inclusive) when the previous evaluated sample was outside that band.
- R7: Condition code 3 (high hysteresis) arms on a level below `lvl_lo`. While armed, a level above `lvl_hi` fires and disarms. Without arming, levels above `lvl_hi` do not fire.
- R8: Condition code 4 (low hysteresis) arms on a level above `lvl_hi`. While armed, a level below `lvl_lo` fires and disarms. Without arming, levels below `lvl_lo` do not fire.
- R9: Condition codes 5 to 7 never produce a trigger.
- R10: A change of `cond_sel` or `src_sel` clears the history (previous-sample state and arming). The first qualifying sample under the new setting may therefore fire at once.
- R11: During reset `trig_pulse` is low. After reset the history is empty, so a first qualifying sample fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | NUM_SRC*SAMPLE_W | Packed samples of all streams |
| smp_valid | input | NUM_SRC | Per-stream sample strobes |
| src_sel | input | SEL_W | Index of the monitored stream |
| lvl_lo | input | 8 | Low trigger level |
| lvl_hi | input | 8 | High trigger level |
| cond_sel | input | 3 | Trigger condition code |
| trig_pulse | output | 1 | One-cycle trigger pulse |

## Verification
The bench probes the inclusive edges of the band. A level equal to `lvl_lo` must count as inside and not below, and a level equal to `lvl_hi` must count as inside and not above. An off-by-one comparator would fire one code early or late.

It repeats qualifying samples to prove that a level condition fires only once. A design that tests the level instead of the edge would pulse on every sample. For the hysteresis modes, it offers a firing level before arming and again right after a firing. A design lacking the arm flag, or failing to clear it, would fire at those points.

It also changes the condition code and the source between samples that would otherwise be suppressed. A design that keeps stale history would miss the immediate trigger. Finally, it drives firing values on unselected streams, on an out-of-range select, with the strobe low, and in the low sample bits. Each of these must leave the pulse low.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int LVL_W = 8;

    typedef enum logic [2:0] {
        COND_BELOW   = 3'd0,
        COND_ABOVE   = 3'd1,
        COND_INSIDE  = 3'd2,
        COND_HYST_HI = 3'd3,
        COND_HYST_LO = 3'd4
    } cond_e;

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
    parameter int NUM_SRC  = 5,
    parameter int SAMPLE_W = 16,
    parameter int SEL_W    = 3,
    parameter int LVL_W    = 8
) (
    input  logic [NUM_SRC*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_SRC-1:0]          smp_valid,
    input  logic [SEL_W-1:0]            src_sel,
    output logic [LVL_W-1:0]            mon_lvl,
    output logic                        mon_ok
);
    logic [SAMPLE_W-1:0] chan [NUM_SRC];
    logic [SAMPLE_W-1:0] pick;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_unpack
            assign chan[g] = smp_data[g*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    always_comb begin
        pick   = '0;
        mon_ok = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel == SEL_W'(i)) begin
                pick   = chan[i];
                mon_ok = smp_valid[i];
            end
        end
    end

    assign mon_lvl = pick[SAMPLE_W-1 -: LVL_W];

endmodule

// File: rtl/trig_level_cmp.sv
module trig_level_cmp #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0] mon_lvl,
    input  logic [LVL_W-1:0] lvl_lo,
    input  logic [LVL_W-1:0] lvl_hi,
    output logic             is_below,
    output logic             is_above,
    output logic             is_inside
);
    assign is_below  = mon_lvl < lvl_lo;
    assign is_above  = mon_lvl > lvl_hi;
    assign is_inside = (mon_lvl >= lvl_lo) && (mon_lvl <= lvl_hi);
endmodule

// File: rtl/trig_cond_fsm.sv
module trig_cond_fsm
    import trig_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_ok,
    input  logic             is_below,
    input  logic             is_above,
    input  logic             is_inside,
    input  logic [2:0]       cond_sel,
    input  logic [SEL_W-1:0] src_sel,
    output logic             trig
);
    typedef struct packed {
        logic             hit;
        logic             armed;
        logic             trig;
        logic [2:0]       cond;
        logic [SEL_W-1:0] sel;
    } st_t;

    st_t st_q, st_d;
    logic reconfig;
    logic hist_hit, hist_armed;

    always_comb begin
        st_d       = st_q;
        st_d.trig  = 1'b0;
        st_d.cond  = cond_sel;
        st_d.sel   = src_sel;
        reconfig   = (cond_sel != st_q.cond) || (src_sel != st_q.sel);
        hist_hit   = reconfig ? 1'b0 : st_q.hit;
        hist_armed = reconfig ? 1'b0 : st_q.armed;
        st_d.hit   = hist_hit;
        st_d.armed = hist_armed;
        if (mon_ok) begin
            case (cond_sel)
                COND_BELOW: begin
                    st_d.trig = is_below && !hist_hit;
                    st_d.hit  = is_below;
                end
                COND_ABOVE: begin
                    st_d.trig = is_above && !hist_hit;
                    st_d.hit  = is_above;
                end
                COND_INSIDE: begin
                    st_d.trig = is_inside && !hist_hit;
                    st_d.hit  = is_inside;
                end
                COND_HYST_HI: begin
                    if (hist_armed && is_above) begin
                        st_d.trig  = 1'b1;
                        st_d.armed = 1'b0;
                    end else if (is_below) begin
                        st_d.armed = 1'b1;
                    end
                end
                COND_HYST_LO: begin
                    if (hist_armed && is_below) begin
                        st_d.trig  = 1'b1;
                        st_d.armed = 1'b0;
                    end else if (is_above) begin
                        st_d.armed = 1'b1;
                    end
                end
                default: begin
                    st_d.hit   = 1'b0;
                    st_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hit: 1'b0, armed: 1'b0, trig: 1'b0,
                      cond: COND_BELOW, sel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign trig = st_q.trig;

endmodule

// File: rtl/trig_level_detector.sv
module trig_level_detector #(
    parameter int NUM_SRC  = 5,
    parameter int SAMPLE_W = 16,
    parameter int SEL_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_SRC-1:0]          smp_valid,
    input  logic [SEL_W-1:0]            src_sel,
    input  logic [7:0]                  lvl_lo,
    input  logic [7:0]                  lvl_hi,
    input  logic [2:0]                  cond_sel,
    output logic                        trig_pulse
);
    localparam int LVL_W = trig_pkg::LVL_W;

    logic [LVL_W-1:0] mon_lvl;
    logic             mon_ok;
    logic             is_below, is_above, is_inside;

    trig_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SAMPLE_W(SAMPLE_W),
        .SEL_W   (SEL_W),
        .LVL_W   (LVL_W)
    ) u_mux (
        .smp_data (smp_data),
        .smp_valid(smp_valid),
        .src_sel  (src_sel),
        .mon_lvl  (mon_lvl),
        .mon_ok   (mon_ok)
    );

    trig_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .mon_lvl  (mon_lvl),
        .lvl_lo   (lvl_lo),
        .lvl_hi   (lvl_hi),
        .is_below (is_below),
        .is_above (is_above),
        .is_inside(is_inside)
    );

    trig_cond_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_ok   (mon_ok),
        .is_below (is_below),
        .is_above (is_above),
        .is_inside(is_inside),
        .cond_sel (cond_sel),
        .src_sel  (src_sel),
        .trig     (trig_pulse)
    );

endmodule

// File: rtl/trig_level_detector_chk.sv
module trig_level_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cond_sel,
    input logic [7:0] lvl_lo,
    input logic [7:0] lvl_hi,
    input logic [7:0] mon_lvl,
    input logic       mon_ok,
    input logic       trig_pulse
);
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> !trig_pulse);

    assert_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(mon_ok));

    assert_below_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(cond_sel) == 3'd0) |-> ($past(mon_lvl) < $past(lvl_lo)));

    assert_above_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(cond_sel) == 3'd1) |-> ($past(mon_lvl) > $past(lvl_hi)));

    assert_in_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(cond_sel) == 3'd2) |->
        ($past(mon_lvl) >= $past(lvl_lo) && $past(mon_lvl) <= $past(lvl_hi)));

    assert_hyst_hi_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(cond_sel) == 3'd3) |-> ($past(mon_lvl) > $past(lvl_hi)));

    assert_hyst_lo_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(cond_sel) == 3'd4) |-> ($past(mon_lvl) < $past(lvl_lo)));

    assert_bad_code_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(cond_sel) <= 3'd4));

endmodule

bind trig_level_detector trig_level_detector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_sel  (cond_sel),
    .lvl_lo    (lvl_lo),
    .lvl_hi    (lvl_hi),
    .mon_lvl   (mon_lvl),
    .mon_ok    (mon_ok),
    .trig_pulse(trig_pulse)
);

// File: tb/trig_level_detector_bench.sv
`timescale 1ns/1ps
module trig_level_detector_bench;
    localparam int NS = 5;
    localparam int SW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS*SW-1:0] smp_data = '0;
    logic [NS-1:0]  smp_valid = '0;
    logic [2:0]     src_sel = 3'd0;
    logic [7:0]     lvl_lo = 8'h40;
    logic [7:0]     lvl_hi = 8'hC0;
    logic [2:0]     cond_sel = 3'd0;
    logic           trig_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_level_detector u_trig_level_detector (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .src_sel(src_sel), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi),
        .cond_sel(cond_sel), .trig_pulse(trig_pulse)
    );

    task automatic check(input bit exp, input string req);
        checks++;
        if (trig_pulse !== exp) begin
            errors++;
            $display("FAIL %s trig_pulse=%b expected=%b t=%0t", req, trig_pulse, exp, $time);
        end
    endtask

    // entered at a negedge, returns at a negedge
    task automatic smp(input int ch, input logic [15:0] v, input bit vld,
                       input bit exp, input string req);
        smp_data[ch*SW +: SW] = v;
        smp_valid = '0;
        if (vld) smp_valid[ch] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(exp, req);
        smp_valid = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(1'b0, "R11 during reset");
        rst_n = 1'b1;
        idle();
        check(1'b0, "R11 after reset");
        smp(0, 16'h3000, 1, 1'b1, "R11 first qualifying sample");
    endtask

    task automatic t_below();
        smp(0, 16'h5000, 1, 1'b0, "R4 not below");
        smp(0, 16'h3000, 1, 1'b1, "R4 below edge");
        smp(0, 16'h2000, 1, 1'b0, "R4 still below no repeat");
        smp(0, 16'h5000, 1, 1'b0, "R4 leave");
        smp(0, 16'h3FFF, 1, 1'b1, "R2 low bits ignored 3F below");
        smp(0, 16'h40FF, 1, 1'b0, "R2 40 not below");
        smp(0, 16'h1000, 0, 1'b0, "R3 no strobe");
        smp(0, 16'h1000, 1, 1'b1, "R3 strobed sample");
    endtask

    task automatic t_above();
        cond_sel = 3'd1;
        smp(0, 16'hC000, 1, 1'b0, "R5 equal hi not above");
        smp(0, 16'hC100, 1, 1'b1, "R5 above edge");
        smp(0, 16'hFF00, 1, 1'b0, "R5 no repeat");
        smp(0, 16'h8000, 1, 1'b0, "R5 leave");
        smp(0, 16'hD000, 1, 1'b1, "R5 re-enter");
        cond_sel = 3'd0;
        idle();
        cond_sel = 3'd1;
        smp(0, 16'hD000, 1, 1'b1, "R10 cond change clears history");
    endtask

    task automatic t_inside();
        cond_sel = 3'd2;
        smp(0, 16'h2000, 1, 1'b0, "R6 under band");
        smp(0, 16'h4000, 1, 1'b1, "R6 low bound inclusive");
        smp(0, 16'hC000, 1, 1'b0, "R6 high bound no repeat");
        smp(0, 16'hC100, 1, 1'b0, "R6 over band");
        smp(0, 16'hC000, 1, 1'b1, "R6 high bound entry");
        smp(0, 16'h8000, 1, 1'b0, "R6 stays inside");
    endtask

    task automatic t_hyst_hi();
        cond_sel = 3'd3;
        smp(0, 16'hD000, 1, 1'b0, "R7 high unarmed");
        smp(0, 16'h8000, 1, 1'b0, "R7 mid");
        smp(0, 16'h3000, 1, 1'b0, "R7 arm");
        smp(0, 16'h8000, 1, 1'b0, "R7 mid armed");
        smp(0, 16'hC100, 1, 1'b1, "R7 fire");
        smp(0, 16'hD000, 1, 1'b0, "R7 disarmed");
        smp(0, 16'h3000, 1, 1'b0, "R7 re-arm");
        smp(0, 16'hD000, 1, 1'b1, "R7 fire again");
    endtask

    task automatic t_hyst_lo();
        cond_sel = 3'd4;
        smp(0, 16'h3000, 1, 1'b0, "R8 low unarmed");
        smp(0, 16'hD000, 1, 1'b0, "R8 arm");
        smp(0, 16'h8000, 1, 1'b0, "R8 mid armed");
        smp(0, 16'h3F00, 1, 1'b1, "R8 fire");
        smp(0, 16'h2000, 1, 1'b0, "R8 disarmed");
        smp(0, 16'hD000, 1, 1'b0, "R8 re-arm");
        smp(0, 16'h4000, 1, 1'b0, "R8 equal lo not below");
        smp(0, 16'h1000, 1, 1'b1, "R8 fire again");
    endtask

    task automatic t_bad_code();
        cond_sel = 3'd5;
        smp(0, 16'h1000, 1, 1'b0, "R9 code5 low");
        smp(0, 16'hD000, 1, 1'b0, "R9 code5 high");
        cond_sel = 3'd6;
        smp(0, 16'h8000, 1, 1'b0, "R9 code6 mid");
        cond_sel = 3'd7;
        smp(0, 16'h1000, 1, 1'b0, "R9 code7 low");
    endtask

    task automatic t_source();
        cond_sel = 3'd0;
        src_sel = 3'd2;
        smp(0, 16'h1000, 1, 1'b0, "R1 unselected stream ignored");
        smp(2, 16'h1000, 1, 1'b1, "R1 selected stream");
        smp_data[3*SW +: SW] = 16'h1000;
        src_sel = 3'd3;
        smp(3, 16'h1000, 1, 1'b1, "R10 source change clears history");
        src_sel = 3'd4;
        smp(4, 16'h1000, 1, 1'b1, "R1 external stream");
        src_sel = 3'd7;
        for (int c = 0; c < NS; c++) begin
            smp(c, 16'h0500, 1, 1'b0, "R1 out of range select");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_below();
        t_above();
        t_inside();
        t_hyst_hi();
        t_hyst_lo();
        t_bad_code();
        t_source();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule